// File: doc/BRIEF.md
# Owner-Gated Way-Partitioned Cache Tag Array

This block is the tag side of a set-associative cache in which every way belongs to at most one process identifier. Each lookup names the requesting process, a set and a tag. Only the ways that this process owns take part in the access: they alone may report a hit, and on a miss they alone supply the line to replace. Lines held in another process's ways can neither be seen nor displaced, so one process cannot build a timing channel by evicting another's lines.

Ownership is set through a configuration port. A request names the requester and the process whose way mask it wants to write. The write takes effect only when both identifiers match and the new mask claims no way that another process already holds. Anything else is refused and reported with an error pulse. A way that leaves a mask has its lines invalidated in every set, so the next owner starts with empty storage. A process whose mask is empty is uncacheable. Every lookup it makes misses and allocates nothing.

Top module: `wpc_part_cache`

## Requirements
- R1: While reset is held, every output is 0. After reset every way mask is empty and every line is invalid.
- R2: A lookup accepted at a clock edge gives rsp_valid=1 one cycle later. rsp_hit=1 and rsp_way give the way when that way holds the tag as a valid line in that set and belongs to the requester.
- R3: A valid line with a matching tag in a way owned by another process never produces a hit.
- R4: On a miss with a non-empty mask, rsp_fill=1 and the tag is written into the way given by rsp_way. That way is picked round-robin over the requester's own ways. Each process keeps its own pointer, which starts at way 0. The pointer searches upward from its value, wrapping at the top, for the first way in the mask, and afterwards moves to that way plus one, modulo the way count.
- R5: When the way picked for a fill already held a valid line, rsp_evict=1 and rsp_evict_tag gives that line's tag. Otherwise rsp_evict=0.
- R6: A lookup from a process whose mask is all zeros gives rsp_valid=1, rsp_hit=0 and rsp_fill=0, and writes nothing.
- R7: A configuration request is accepted when the requester equals the target and the new mask (bit i = way i) has no bit in common with any other process's mask. The new mask is used from the next cycle on, and cfg_err stays 0.
- R8: Any other configuration request leaves every mask unchanged, and cfg_err is 1 for exactly the cycle after it.
- R9: When an accepted request removes a way from the target's mask, every line in that way is invalidated in all sets.
- R10: A lookup presented in the same cycle as a configuration request is dropped. rsp_valid is 0 the next cycle and the storage is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_pid | input | PID_W | Process issuing the lookup |
| lk_set | input | SET_W | Set index |
| lk_tag | input | TAG_W | Tag to look up |
| cfg_valid | input | 1 | Mask write request |
| cfg_req_pid | input | PID_W | Process making the mask write |
| cfg_tgt_pid | input | PID_W | Process whose mask is written |
| cfg_mask | input | WAYS | New way mask, bit i is way i |
| rsp_valid | output | 1 | Lookup result is valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_fill | output | 1 | Miss that allocated a way |
| rsp_way | output | WAY_W | Way that hit or was filled |
| rsp_evict | output | 1 | The fill displaced a valid line |
| rsp_evict_tag | output | TAG_W | Tag of the displaced line |
| cfg_err | output | 1 | Mask write was refused |

## Verification
Each lookup result (hit, way, fill, eviction and displaced tag) is registered once. It is due on the first rising edge after the request. The configuration error flag and the new mask follow the same single-edge rule. The bench drives every request on a falling edge and reads the outputs on the next falling edge, half a cycle after the edge that produced them. It leaves an idle cycle between requests, so each reading belongs to exactly one request. A mask change or an invalidation is then checked through lookups made in later cycles.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
   typedef enum logic [1:0] {
      CFG_NONE    = 2'd0,
      CFG_TAKEN   = 2'd1,
      CFG_REFUSED = 2'd2
   } cfg_res_e;
endpackage

// File: rtl/wpc_mask_table.sv
module wpc_mask_table
   import wpc_pkg::*;
#(
   parameter int WAYS    = 4,
   parameter int NUM_IDS = 4,
   parameter int PID_W   = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_valid,
   input  logic [PID_W-1:0]                  cfg_req_pid,
   input  logic [PID_W-1:0]                  cfg_tgt_pid,
   input  logic [WAYS-1:0]                   cfg_mask,
   output logic [NUM_IDS-1:0][WAYS-1:0]      masks_q,
   output logic [WAYS-1:0]                   drop_ways,
   output logic                              cfg_err_q
);
   logic [WAYS-1:0] others;
   cfg_res_e        res;

   // ways held by processes other than the target
   always_comb begin
      others = '0;
      for (int j = 0; j < NUM_IDS; j++) begin
         if (PID_W'(j) != cfg_tgt_pid) others = others | masks_q[j];
      end
   end

   always_comb begin
      if (!cfg_valid)
         res = CFG_NONE;
      else if ((cfg_req_pid == cfg_tgt_pid) && ((cfg_mask & others) == '0))
         res = CFG_TAKEN;
      else
         res = CFG_REFUSED;
      drop_ways = (res == CFG_TAKEN) ? (masks_q[cfg_tgt_pid] & ~cfg_mask) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         masks_q   <= '0;
         cfg_err_q <= 1'b0;
      end else begin
         cfg_err_q <= (res == CFG_REFUSED);
         if (res == CFG_TAKEN) masks_q[cfg_tgt_pid] <= cfg_mask;
      end
   end
endmodule

// File: rtl/wpc_rr_pick.sv
module wpc_rr_pick #(
   parameter int WAYS    = 4,
   parameter int NUM_IDS = 4,
   parameter int PID_W   = 2,
   parameter int WAY_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PID_W-1:0]   pid,
   input  logic [WAYS-1:0]    own_mask,
   input  logic               advance,
   output logic [WAY_W-1:0]   victim
);
   logic [NUM_IDS-1:0][WAY_W-1:0] ptr_q;
   logic [WAY_W-1:0]              idx;

   // search from the pointer upward, wrapping; the lowest offset wins
   always_comb begin
      victim = '0;
      idx    = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         idx = ptr_q[pid] + WAY_W'(i);
         if (own_mask[idx]) victim = idx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else if (advance) ptr_q[pid] <= victim + WAY_W'(1);
   end
endmodule

// File: rtl/wpc_tag_store.sv
module wpc_tag_store #(
   parameter int WAYS  = 4,
   parameter int SETS  = 64,
   parameter int TAG_W = 8,
   parameter int SET_W = 6,
   parameter int WAY_W = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [SET_W-1:0]            rd_set,
   input  logic [TAG_W-1:0]            rd_tag,
   output logic [WAYS-1:0]             match_vec,
   output logic [WAYS-1:0]             valid_row,
   output logic [WAYS-1:0][TAG_W-1:0]  tag_row,
   input  logic                        wr_en,
   input  logic [WAY_W-1:0]            wr_way,
   input  logic [TAG_W-1:0]            wr_tag,
   input  logic [WAYS-1:0]             inv_ways
);
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0] tags [SETS];
      logic [SETS-1:0]  vld_q;
      logic             wr_here;

      assign wr_here = wr_en && (wr_way == WAY_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          vld_q <= '0;
         else if (inv_ways[w]) vld_q <= '0;
         else if (wr_here)     vld_q[rd_set] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (wr_here) tags[rd_set] <= wr_tag;
      end

      assign valid_row[w] = vld_q[rd_set];
      assign tag_row[w]   = tags[rd_set];
      assign match_vec[w] = vld_q[rd_set] && (tags[rd_set] == rd_tag);
   end
endmodule

// File: rtl/wpc_part_cache.sv
module wpc_part_cache #(
   parameter int WAYS    = 4,
   parameter int SETS    = 64,
   parameter int NUM_IDS = 4,
   parameter int TAG_W   = 8,
   localparam int WAY_W  = $clog2(WAYS),
   localparam int SET_W  = $clog2(SETS),
   localparam int PID_W  = $clog2(NUM_IDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lk_valid,
   input  logic [PID_W-1:0]   lk_pid,
   input  logic [SET_W-1:0]   lk_set,
   input  logic [TAG_W-1:0]   lk_tag,
   input  logic               cfg_valid,
   input  logic [PID_W-1:0]   cfg_req_pid,
   input  logic [PID_W-1:0]   cfg_tgt_pid,
   input  logic [WAYS-1:0]    cfg_mask,
   output logic               rsp_valid,
   output logic               rsp_hit,
   output logic               rsp_fill,
   output logic [WAY_W-1:0]   rsp_way,
   output logic               rsp_evict,
   output logic [TAG_W-1:0]   rsp_evict_tag,
   output logic               cfg_err
);
   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (SETS < 2 || (1 << SET_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (NUM_IDS < 2 || (1 << PID_W) != NUM_IDS) begin : g_bad_ids
      $error("NUM_IDS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("TAG_W must be positive");
   end

   logic [NUM_IDS-1:0][WAYS-1:0] masks_q;
   logic [WAYS-1:0]              drop_ways;
   logic [WAYS-1:0]              own_mask;
   logic [WAYS-1:0]              match_vec, hit_vec, valid_row;
   logic [WAYS-1:0][TAG_W-1:0]   tag_row;
   logic [WAY_W-1:0]             victim, hit_way;
   logic                         lk_go, hit, fill;

   wpc_mask_table #(.WAYS(WAYS), .NUM_IDS(NUM_IDS), .PID_W(PID_W)) u_masks (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid),
      .cfg_req_pid(cfg_req_pid), .cfg_tgt_pid(cfg_tgt_pid), .cfg_mask(cfg_mask),
      .masks_q(masks_q), .drop_ways(drop_ways), .cfg_err_q(cfg_err)
   );

   assign lk_go    = lk_valid && !cfg_valid;
   assign own_mask = masks_q[lk_pid];

   wpc_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W)) u_store (
      .clk(clk), .rst_n(rst_n), .rd_set(lk_set), .rd_tag(lk_tag),
      .match_vec(match_vec), .valid_row(valid_row), .tag_row(tag_row),
      .wr_en(fill), .wr_way(victim), .wr_tag(lk_tag), .inv_ways(drop_ways)
   );

   wpc_rr_pick #(.WAYS(WAYS), .NUM_IDS(NUM_IDS), .PID_W(PID_W), .WAY_W(WAY_W)) u_rr (
      .clk(clk), .rst_n(rst_n), .pid(lk_pid), .own_mask(own_mask),
      .advance(fill), .victim(victim)
   );

   assign hit_vec = match_vec & own_mask;
   assign hit     = lk_go && (hit_vec != '0);
   assign fill    = lk_go && (hit_vec == '0) && (own_mask != '0);

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_hit       <= 1'b0;
         rsp_fill      <= 1'b0;
         rsp_way       <= '0;
         rsp_evict     <= 1'b0;
         rsp_evict_tag <= '0;
      end else begin
         rsp_valid     <= lk_go;
         rsp_hit       <= hit;
         rsp_fill      <= fill;
         rsp_way       <= hit ? hit_way : (fill ? victim : '0);
         rsp_evict     <= fill && valid_row[victim];
         rsp_evict_tag <= (fill && valid_row[victim]) ? tag_row[victim] : '0;
      end
   end
endmodule

// File: rtl/wpc_part_chk.sv
module wpc_part_chk #(
   parameter int WAYS    = 4,
   parameter int NUM_IDS = 4,
   parameter int PID_W   = 2,
   parameter int WAY_W   = 2
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         lk_valid,
   input logic [PID_W-1:0]             lk_pid,
   input logic                         cfg_valid,
   input logic [NUM_IDS-1:0][WAYS-1:0] masks_q,
   input logic                         rsp_valid,
   input logic                         rsp_hit,
   input logic                         rsp_fill,
   input logic [WAY_W-1:0]             rsp_way,
   input logic                         cfg_err
);
   logic [WAYS-1:0] own_now, uni;
   int              total;

   assign own_now = masks_q[lk_pid];

   always_comb begin
      uni   = '0;
      total = 0;
      for (int i = 0; i < NUM_IDS; i++) begin
         uni   = uni | masks_q[i];
         total = total + $countones(masks_q[i]);
      end
   end

   a_r7_ways_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(uni) == total);

   a_r2_hit_in_own_way: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> ((($past(own_now) >> rsp_way) & WAYS'(1)) != '0));

   a_r4_fill_in_own_way: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fill |-> ((($past(own_now) >> rsp_way) & WAYS'(1)) != '0));

   a_r6_empty_mask_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && ($past(own_now) == '0)) |-> (!rsp_hit && !rsp_fill));

   a_r8_refusal_keeps_masks: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> $stable(masks_q));

   a_r10_lookup_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_valid) |-> !rsp_valid);

   a_r2_hit_fill_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_hit && rsp_fill));
endmodule

bind wpc_part_cache wpc_part_chk #(
   .WAYS(WAYS), .NUM_IDS(NUM_IDS), .PID_W(PID_W), .WAY_W(WAY_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pid(lk_pid),
   .cfg_valid(cfg_valid), .masks_q(masks_q), .rsp_valid(rsp_valid),
   .rsp_hit(rsp_hit), .rsp_fill(rsp_fill), .rsp_way(rsp_way), .cfg_err(cfg_err)
);

// File: tb/wpc_part_cache_tb.sv
module wpc_part_cache_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W = 4;
   localparam int S = 64;
   localparam int N = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lk_valid = 1'b0;
   logic [1:0] lk_pid = '0;
   logic [5:0] lk_set = '0;
   logic [7:0] lk_tag = '0;
   logic       cfg_valid = 1'b0;
   logic [1:0] cfg_req_pid = '0, cfg_tgt_pid = '0;
   logic [3:0] cfg_mask = '0;
   logic       rsp_valid, rsp_hit, rsp_fill, rsp_evict, cfg_err;
   logic [1:0] rsp_way;
   logic [7:0] rsp_evict_tag;

   always #(CLK_PERIOD / 2) clk = ~clk;

   wpc_part_cache u_dut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pid(lk_pid),
      .lk_set(lk_set), .lk_tag(lk_tag), .cfg_valid(cfg_valid),
      .cfg_req_pid(cfg_req_pid), .cfg_tgt_pid(cfg_tgt_pid), .cfg_mask(cfg_mask),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fill(rsp_fill),
      .rsp_way(rsp_way), .rsp_evict(rsp_evict), .rsp_evict_tag(rsp_evict_tag),
      .cfg_err(cfg_err)
   );

   int n_tests = 0;
   int n_fail = 0;
   bit finished = 0;
   int mmask [N];
   bit mval [S][W];
   int mtag [S][W];
   int mptr [N];
   int saved [S];

   task automatic check(string req, string what, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   function automatic int tag_of(int set, int pid, int round);
      return (set * 7 + pid * 61 + round * 13) & 255;
   endfunction

   // one lookup, expected values from the requirement model
   task automatic lookup(int pid, int set, int tag);
      int m, eh, ef, ew, ev, et;
      @(negedge clk);
      lk_valid = 1'b1; lk_pid = 2'(pid); lk_set = 6'(set); lk_tag = 8'(tag);
      m = mmask[pid]; eh = 0; ef = 0; ew = 0; ev = 0; et = 0;
      for (int w = 0; w < W; w++)
         if (m[w] && mval[set][w] && mtag[set][w] == tag) begin eh = 1; ew = w; end
      if (eh == 0 && m != 0) begin
         for (int i = W - 1; i >= 0; i--)
            if (m[(mptr[pid] + i) % W]) ew = (mptr[pid] + i) % W;
         ef = 1;
         ev = mval[set][ew];
         et = ev ? mtag[set][ew] : 0;
         mval[set][ew] = 1;
         mtag[set][ew] = tag;
         mptr[pid] = (ew + 1) % W;
      end
      @(negedge clk);
      lk_valid = 1'b0;
      check("R2", "rsp_valid", int'(rsp_valid), 1);
      check("R2", "hit", int'(rsp_hit), eh);
      check(m == 0 ? "R6" : "R4", "fill", int'(rsp_fill), ef);
      if (eh != 0 || ef != 0) check(eh != 0 ? "R2" : "R4", "way", int'(rsp_way), ew);
      check("R5", "evict", int'(rsp_evict), ev);
      if (ev != 0) check("R5", "evict_tag", int'(rsp_evict_tag), et);
   endtask

   task automatic configure(int req, int tgt, int mask, bit with_lk);
      int others, acc, drop;
      @(negedge clk);
      cfg_valid = 1'b1; cfg_req_pid = 2'(req); cfg_tgt_pid = 2'(tgt); cfg_mask = 4'(mask);
      if (with_lk) begin
         lk_valid = 1'b1; lk_pid = 2'(tgt); lk_set = 6'd3; lk_tag = 8'(tag_of(3, tgt, 9));
      end
      others = 0;
      for (int j = 0; j < N; j++) if (j != tgt) others |= mmask[j];
      acc = (req == tgt && (mask & others) == 0) ? 1 : 0;
      if (acc != 0) begin
         drop = mmask[tgt] & ~mask;
         for (int s = 0; s < S; s++)
            for (int w = 0; w < W; w++) if (drop[w]) mval[s][w] = 0;
         mmask[tgt] = mask;
      end
      @(negedge clk);
      cfg_valid = 1'b0; lk_valid = 1'b0;
      check(acc != 0 ? "R7" : "R8", "cfg_err", int'(cfg_err), 1 - acc);
      if (with_lk) check("R10", "rsp_valid", int'(rsp_valid), 0);
      @(negedge clk);
      check("R8", "cfg_err pulse width", int'(cfg_err), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < N; i++) begin mmask[i] = 0; mptr[i] = 0; end
      for (int s = 0; s < S; s++)
         for (int w = 0; w < W; w++) begin mval[s][w] = 0; mtag[s][w] = 0; end

      repeat (3) @(negedge clk);
      check("R1", "rsp_valid in reset", int'(rsp_valid), 0);
      check("R1", "rsp_hit in reset", int'(rsp_hit), 0);
      check("R1", "rsp_fill in reset", int'(rsp_fill), 0);
      check("R1", "cfg_err in reset", int'(cfg_err), 0);
      rst_n = 1'b1;

      // R1 / R6: nothing owned after reset, every process is uncacheable
      for (int p = 0; p < N; p++)
         for (int k = 0; k < 3; k++) begin
            lookup(p, k * 31, tag_of(k * 31, p, 0));
            check("R1", "fill after reset", int'(rsp_fill), 0);
         end

      // R7 / R8: claims and refusals
      configure(0, 0, 4'b0011, 0);
      configure(1, 1, 4'b0100, 0);
      configure(2, 2, 4'b1000, 0);
      configure(3, 0, 4'b1111, 0);
      configure(3, 3, 4'b0001, 0);
      configure(0, 0, 4'b0111, 0);

      // R2 / R4 / R5: fill, evict and hit sweeps over all sets and processes
      for (int r = 0; r < 3; r++)
         for (int s = 0; s < S; s++)
            for (int p = 0; p < N; p++) lookup(p, s, tag_of(s, p, r));
      for (int s = 0; s < S; s++)
         for (int p = 0; p < N; p++) begin
            lookup(p, s, tag_of(s, p, 2));
            lookup(p, s, tag_of(s, p, 1));
         end

      // R3: another process's line is invisible
      for (int s = 0; s < S; s += 9) begin
         lookup(1, s, mtag[s][0]);
         check("R3", "foreign line hit", int'(rsp_hit), 0);
      end

      // R9: releasing way 1 drops its lines everywhere
      for (int s = 0; s < S; s++) saved[s] = mtag[s][1];
      configure(0, 0, 4'b0001, 0);
      for (int s = 0; s < S; s++) begin
         lookup(0, s, saved[s]);
         check("R9", "hit on released way", int'(rsp_hit), 0);
      end
      configure(3, 3, 4'b0010, 0);
      for (int s = 0; s < S; s++) begin
         lookup(3, s, tag_of(s, 3, 4));
         check("R9", "evict into freed way", int'(rsp_evict), 0);
      end

      // R10: a lookup alongside a configuration request is dropped
      configure(2, 2, 4'b1000, 1);
      configure(3, 1, 4'b0000, 1);
      lookup(2, 3, tag_of(3, 2, 9));
      check("R10", "dropped lookup left no line", int'(rsp_hit), 0);

      // R6: a process that gives up its ways becomes uncacheable
      configure(1, 1, 4'b0000, 0);
      for (int s = 0; s < S; s += 7) lookup(1, s, tag_of(s, 1, 2));
      configure(3, 3, 4'b0110, 0);
      for (int s = 0; s < 8; s++) lookup(3, s, tag_of(s, 3, 5));

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule